// File: doc/BRIEF.md
# Flash Fetch Accelerator With Wait-States

This block sits between a processor's read port and a slow flash array. Each array access takes a programmed number of clock cycles. The block keeps the last fetched flash line in holding registers: one for instruction fetches and one for data reads. A later read that falls in the same line can then be answered in one cycle without using the array. A small register port holds two registers. The accelerator mode register turns line reuse off, on for instructions only, or on for both kinds of read. The timing register sets the length of each array access.

A request is taken when `req_valid` and `req_ready` are both high at a rising clock edge. A hit answers in the next cycle with `rsp_hit` set. A miss drives `flash_req` and `flash_addr` for the programmed number of cycles. The answer comes in the last of those cycles, and the holding register is filled at the end of that same cycle. Any write that changes the mode drops every held line. Software may do this at any time, including while an array access is in progress.

Top module: `fetch_accel`

## Requirements
- R1: After reset the mode register reads 0 (acceleration off) and the timing register reads 7. `rsp_valid` and `flash_req` are low and `req_ready` is high.
- R2: When `reg_addr` is 0, `reg_rdata[1:0]` is the mode and `reg_rdata[7:2]` reads 0. When `reg_addr` is 1, `reg_rdata[2:0]` is the raw timing value and `reg_rdata[7:3]` reads 0. Writes to the unused bits have no effect.
- R3: Writing mode code 11 has no effect. The previous mode stays, and no held line is dropped.
- R4: A miss accepted at an edge keeps `flash_req` high for T cycles with `flash_addr` equal to `req_addr[15:2]`. `rsp_valid` is high in the T-th cycle after the edge, with `rsp_data` equal to `flash_rdata` and `rsp_hit` low. T is the timing value, and a timing value of 0 acts as 1.
- R5: A hit answers in the first cycle after acceptance with `rsp_hit` high and the held line on `rsp_data`, and `flash_req` stays low. Addresses that differ only in bits 1:0 fall in the same line.
- R6: In mode 00 every request misses.
- R7: In mode 01 instruction fetches (`req_is_data`=0) may hit. Data reads always miss and never replace the held instruction line.
- R8: In mode 10 both kinds of read may hit, each against its own held line, and neither kind displaces the other.
- R9: A write that changes the mode drops both held lines. A write of the current mode value drops nothing.
- R10: If the mode changes while an array access is in progress, that access still runs its full length and returns the array data, but its line is not kept. A timing write during an access does not change that access's length.
- R11: `req_ready` is low while an array access is in progress, and exactly one response is produced for each accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 mode, 1 timing |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Block can take a request |
| req_addr | input | 16 | Read address; bits 15:2 select the line |
| req_is_data | input | 1 | 1 for a data read, 0 for an instruction fetch |
| rsp_valid | output | 1 | Response present this cycle |
| rsp_hit | output | 1 | Response served from a held line |
| rsp_data | output | 32 | Line data |
| flash_req | output | 1 | Array access in progress |
| flash_addr | output | 14 | Line address presented to the array |
| flash_rdata | input | 32 | Array read data |

## Verification
The hardest case to reach is a mode change that lands in the middle of a multi-cycle array access. The access must still finish and answer correctly, but its line must not be kept. The bench reaches it by starting a five-cycle miss and then writing a new mode and a new timing value over the register port while `flash_req` is still high. It then re-reads the same address and expects a miss of the new length. Stale-data hits are told apart from fresh misses by changing the array contents between a fill and a later reuse.

// File: rtl/fetch_accel_pkg.sv
package fetch_accel_pkg;

  typedef enum logic [1:0] {
    ACC_OFF  = 2'b00,
    ACC_PART = 2'b01,
    ACC_FULL = 2'b10,
    ACC_RSVD = 2'b11
  } acc_mode_e;

  localparam logic REG_SEL_MODE = 1'b0;
  localparam logic REG_SEL_TIME = 1'b1;

  localparam int KIND_INSN = 0;
  localparam int KIND_DATA = 1;
  localparam int NUM_KINDS = 2;

  // Whether a read of the given kind may use and refill its held line.
  function automatic logic latch_allowed(input acc_mode_e m, input logic is_data);
    case (m)
      ACC_PART: latch_allowed = !is_data;
      ACC_FULL: latch_allowed = 1'b1;
      default:  latch_allowed = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/fa_regs.sv
module fa_regs
  import fetch_accel_pkg::*;
#(
  parameter int DW        = 8,
  parameter int TW        = 3,
  parameter int TIM_RESET = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_i,
  input  logic          sel_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output acc_mode_e     mode_o,
  output logic [TW-1:0] tim_eff_o,
  output logic          inv_o
);

  localparam int MW = 2;

  acc_mode_e     mode_q, mode_d, wmode;
  logic          mode_en;
  logic [TW-1:0] tim_q, tim_d;
  logic          tim_en;
  logic          unused_wbits;

  assign wmode        = acc_mode_e'(wdata_i[MW-1:0]);
  assign unused_wbits = ^wdata_i[DW-1:TW];

  // Next-state: the mode only moves on a legal, different value.
  always_comb begin
    mode_en = wr_i && (sel_i == REG_SEL_MODE) && (wmode != ACC_RSVD) && (wmode != mode_q);
    mode_d  = wmode;
    tim_en  = wr_i && (sel_i == REG_SEL_TIME);
    tim_d   = wdata_i[TW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= ACC_OFF;
      tim_q  <= TW'(TIM_RESET);
    end else begin
      if (mode_en) mode_q <= mode_d;
      if (tim_en)  tim_q  <= tim_d;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (sel_i == REG_SEL_MODE) rdata_o[MW-1:0] = mode_q;
    else                       rdata_o[TW-1:0] = tim_q;
  end

  assign mode_o    = mode_q;
  assign tim_eff_o = (tim_q == '0) ? TW'(1) : tim_q;
  assign inv_o     = mode_en;

  AST_RSVD_KEEPS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && sel_i == REG_SEL_MODE && wdata_i[MW-1:0] == 2'b11) |=> (mode_o == $past(mode_o))); // R3

  AST_SAME_MODE_NO_INV: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && sel_i == REG_SEL_MODE && wdata_i[MW-1:0] == mode_o) |-> !inv_o); // R9

endmodule

// File: rtl/fa_linebuf.sv
module fa_linebuf #(
  parameter int TAGW = 14,
  parameter int LW   = 32,
  parameter int NK   = 2,
  localparam int KW  = (NK > 1) ? $clog2(NK) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            inv_i,
  input  logic [KW-1:0]   look_kind_i,
  input  logic [TAGW-1:0] look_tag_i,
  input  logic            fill_en_i,
  input  logic [KW-1:0]   fill_kind_i,
  input  logic [TAGW-1:0] fill_tag_i,
  input  logic [LW-1:0]   fill_data_i,
  output logic            match_o,
  output logic [LW-1:0]   match_data_o
);

  logic [NK-1:0]   vld_vec;
  logic [TAGW-1:0] tag_arr  [NK];
  logic [LW-1:0]   data_arr [NK];

  for (genvar g = 0; g < NK; g++) begin : g_line
    logic            vld_q, vld_d, load;
    logic [TAGW-1:0] tag_q;
    logic [LW-1:0]   data_q;

    always_comb begin
      load  = fill_en_i && (fill_kind_i == KW'(g));
      vld_d = vld_q;
      if (inv_i)     vld_d = 1'b0;
      else if (load) vld_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vld_q <= 1'b0;
      else        vld_q <= vld_d;
    end

    always_ff @(posedge clk) begin
      if (load) begin
        tag_q  <= fill_tag_i;
        data_q <= fill_data_i;
      end
    end

    assign vld_vec[g]  = vld_q;
    assign tag_arr[g]  = tag_q;
    assign data_arr[g] = data_q;
  end

  assign match_o      = vld_vec[look_kind_i] && (tag_arr[look_kind_i] == look_tag_i);
  assign match_data_o = data_arr[look_kind_i];

  AST_INV_CLEARS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    inv_i |=> (vld_vec == '0)); // R9

  AST_FILL_SETS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en_i && !inv_i) |=> vld_vec[$past(fill_kind_i)]); // R4

endmodule

// File: rtl/fa_waitctr.sv
module fa_waitctr #(
  parameter int TW   = 3,
  parameter int TAGW = 14,
  parameter int KW   = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic [TW-1:0]   tim_i,
  input  logic [TAGW-1:0] tag_i,
  input  logic [KW-1:0]   kind_i,
  input  logic            allow_i,
  input  logic            inv_i,
  output logic            busy_o,
  output logic            done_o,
  output logic [TAGW-1:0] flash_addr_o,
  output logic            fill_en_o,
  output logic [KW-1:0]   fill_kind_o
);

  logic            busy_q, busy_d;
  logic [TW-1:0]   cnt_q, cnt_d;
  logic            ok_q, ok_d;
  logic            load;
  logic [TAGW-1:0] tag_q;
  logic [KW-1:0]   kind_q;

  assign load   = start_i && !busy_q;
  assign done_o = busy_q && (cnt_q == TW'(1));

  // Next-state: the counter runs down once per busy cycle; a mode change
  // during the access withdraws the right to keep the fetched line.
  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    ok_d   = ok_q;
    if (load) begin
      busy_d = 1'b1;
      cnt_d  = tim_i;
      ok_d   = allow_i && !inv_i;
    end else if (busy_q) begin
      if (done_o) busy_d = 1'b0;
      cnt_d = cnt_q - TW'(1);
      if (inv_i) ok_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      ok_q   <= 1'b0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      ok_q   <= ok_d;
    end
  end

  always_ff @(posedge clk) begin
    if (load) begin
      tag_q  <= tag_i;
      kind_q <= kind_i;
    end
  end

  assign busy_o       = busy_q;
  assign flash_addr_o = tag_q;
  assign fill_kind_o  = kind_q;
  assign fill_en_o    = done_o && ok_q && !inv_i;

  AST_CNT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (cnt_q != '0)); // R4

  AST_START_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> (busy_o && cnt_q == $past(tim_i))); // R4

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> $stable(flash_addr_o)); // R4

  AST_INV_BLOCKS_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !done_o && inv_i) |=> !fill_en_o); // R10

endmodule

// File: rtl/fetch_accel.sv
module fetch_accel
  import fetch_accel_pkg::*;
#(
  parameter int AW        = 16,
  parameter int OFS       = 2,
  parameter int LW        = 32,
  parameter int TW        = 3,
  parameter int RDW       = 8,
  parameter int TIM_RESET = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_addr,
  input  logic [RDW-1:0]    reg_wdata,
  output logic [RDW-1:0]    reg_rdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [AW-1:0]     req_addr,
  input  logic              req_is_data,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [LW-1:0]     rsp_data,
  output logic              flash_req,
  output logic [AW-OFS-1:0] flash_addr,
  input  logic [LW-1:0]     flash_rdata
);

  localparam int TAGW = AW - OFS;
  localparam int NK   = NUM_KINDS;
  localparam int KW   = $clog2(NK);

  acc_mode_e       mode;
  logic [TW-1:0]   tim_eff;
  logic            inv;
  logic            busy, done, fill_en;
  logic [KW-1:0]   fill_kind, req_kind;
  logic [TAGW-1:0] req_tag;
  logic            match;
  logic [LW-1:0]   match_data;
  logic            accept, allow, hit_now, start;
  logic            hit_q, hit_d;
  logic [LW-1:0]   hit_data_q;
  logic            unused_offset;

  assign req_tag       = req_addr[AW-1:OFS];
  assign req_kind      = req_is_data ? KW'(KIND_DATA) : KW'(KIND_INSN);
  assign unused_offset = ^req_addr[OFS-1:0];

  fa_regs #(
    .DW        (RDW),
    .TW        (TW),
    .TIM_RESET (TIM_RESET)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_i      (reg_wr),
    .sel_i     (reg_addr),
    .wdata_i   (reg_wdata),
    .rdata_o   (reg_rdata),
    .mode_o    (mode),
    .tim_eff_o (tim_eff),
    .inv_o     (inv)
  );

  fa_linebuf #(
    .TAGW (TAGW),
    .LW   (LW),
    .NK   (NK)
  ) u_lines (
    .clk          (clk),
    .rst_n        (rst_n),
    .inv_i        (inv),
    .look_kind_i  (req_kind),
    .look_tag_i   (req_tag),
    .fill_en_i    (fill_en),
    .fill_kind_i  (fill_kind),
    .fill_tag_i   (flash_addr),
    .fill_data_i  (flash_rdata),
    .match_o      (match),
    .match_data_o (match_data)
  );

  fa_waitctr #(
    .TW   (TW),
    .TAGW (TAGW),
    .KW   (KW)
  ) u_wait (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start),
    .tim_i        (tim_eff),
    .tag_i        (req_tag),
    .kind_i       (req_kind),
    .allow_i      (allow),
    .inv_i        (inv),
    .busy_o       (busy),
    .done_o       (done),
    .flash_addr_o (flash_addr),
    .fill_en_o    (fill_en),
    .fill_kind_o  (fill_kind)
  );

  // Request steering: a permitted match is answered from the held line,
  // everything else starts a timed array access.
  always_comb begin
    accept  = req_valid && req_ready;
    allow   = latch_allowed(mode, req_is_data);
    hit_now = accept && allow && match;
    start   = accept && !hit_now;
    hit_d   = hit_now;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hit_q <= 1'b0;
    else        hit_q <= hit_d;
  end

  always_ff @(posedge clk) begin
    if (hit_now) hit_data_q <= match_data;
  end

  assign req_ready = !busy;
  assign flash_req = busy;
  assign rsp_valid = hit_q || done;
  assign rsp_hit   = hit_q;
  assign rsp_data  = hit_q ? hit_data_q : flash_rdata;

  AST_OFF_NEVER_HITS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && mode == ACC_OFF) |=> !rsp_hit); // R6

  AST_PART_DATA_MISSES: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && mode == ACC_PART && req_is_data) |=> !rsp_hit); // R7

  AST_HIT_NO_ARRAY: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> !flash_req); // R5

  AST_ONE_RSP_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !(rsp_hit && flash_req)); // R11

endmodule

// File: tb/fetch_accel_test.sv
`timescale 1ns/1ps
module fetch_accel_test;

  logic        clk;
  logic        rst_n;
  logic        reg_wr;
  logic        reg_addr;
  logic [7:0]  reg_wdata;
  logic [7:0]  reg_rdata;
  logic        req_valid;
  logic        req_ready;
  logic [15:0] req_addr;
  logic        req_is_data;
  logic        rsp_valid;
  logic        rsp_hit;
  logic [31:0] rsp_data;
  logic        flash_req;
  logic [13:0] flash_addr;
  logic [31:0] flash_rdata;
  logic [7:0]  epoch;

  int checks;
  int fails;
  int cyc;

  typedef struct packed {
    logic [31:0] data;
    logic        hit;
    logic [31:0] lat;
    logic [31:0] acc;
    logic [13:0] line;
  } exp_t;

  exp_t  sb[$];
  string sb_rq[$];

  function automatic logic [31:0] fword(input logic [13:0] la, input logic [7:0] ep);
    return {ep, 10'h000, la};
  endfunction

  assign flash_rdata = fword(flash_addr, epoch);

  fetch_accel uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr      (reg_wr),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .reg_rdata   (reg_rdata),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_addr    (req_addr),
    .req_is_data (req_is_data),
    .rsp_valid   (rsp_valid),
    .rsp_hit     (rsp_hit),
    .rsp_data    (rsp_data),
    .flash_req   (flash_req),
    .flash_addr  (flash_addr),
    .flash_rdata (flash_rdata)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  initial cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", rq, what, act, exp);
    end
  endtask

  // Monitor: counts array cycles of the access at the head of the
  // scoreboard and compares each response as it appears.
  int   fcount;
  bit   abad;
  exp_t cur;
  string cur_rq;
  int   lat_seen;

  always @(negedge clk) begin
    if (rst_n) begin
      if (sb.size() > 0 && cyc >= int'(sb[0].acc) && flash_req) begin
        fcount++;
        if (flash_addr !== sb[0].line) abad = 1'b1;
      end
      if (rsp_valid) begin
        if (sb.size() == 0) begin
          chk(1'b0, "R11", "response without request", 32'd1, 32'd0);
        end else begin
          cur      = sb.pop_front();
          cur_rq   = sb_rq.pop_front();
          lat_seen = cyc - int'(cur.acc) + 1;
          chk(rsp_data === cur.data, cur_rq, "data", rsp_data, cur.data);
          chk(rsp_hit === cur.hit, cur_rq, "hit flag", 32'(rsp_hit), 32'(cur.hit));
          chk(lat_seen == int'(cur.lat), cur_rq, "latency", 32'(lat_seen), cur.lat);
          chk(fcount == (cur.hit ? 0 : int'(cur.lat)) && !abad, cur_rq, "array cycles",
              32'(fcount), cur.hit ? 32'd0 : cur.lat);
          fcount = 0;
          abad   = 1'b0;
        end
      end
    end
  end

  task automatic reg_write(input logic sel, input logic [7:0] val);
    @(negedge clk);
    reg_wr    = 1'b1;
    reg_addr  = sel;
    reg_wdata = val;
    @(negedge clk);
    reg_wr    = 1'b0;
  endtask

  task automatic reg_check(input logic sel, input logic [7:0] exp, input string rq);
    @(negedge clk);
    reg_addr = sel;
    #1;
    chk(reg_rdata === exp, rq, "register read", 32'(reg_rdata), 32'(exp));
  endtask

  // Driver: pushes the expected response, then presents the request.
  task automatic send(input logic [15:0] a, input logic isd, input logic eh,
                      input int lat, input logic [7:0] ep, input string rq);
    exp_t it;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    it.data = fword(a[15:2], ep);
    it.hit  = eh;
    it.lat  = 32'(lat);
    it.acc  = 32'(cyc + 1);
    it.line = a[15:2];
    sb.push_back(it);
    sb_rq.push_back(rq);
    req_valid   = 1'b1;
    req_addr    = a;
    req_is_data = isd;
    @(negedge clk);
    req_valid   = 1'b0;
  endtask

  task automatic drain();
    while (sb.size() != 0) @(negedge clk);
  endtask

  task automatic go(input logic [15:0] a, input logic isd, input logic eh,
                    input int lat, input logic [7:0] ep, input string rq);
    send(a, isd, eh, lat, ep, rq);
    drain();
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    chk(1'b0, "R11", "watchdog expired", 32'd20000, 32'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    checks = 0; fails = 0; fcount = 0; abad = 1'b0;
    epoch = 8'h00;
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = 1'b0; reg_wdata = '0;
    req_valid = 1'b0; req_addr = '0; req_is_data = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    @(negedge clk);
    chk(rsp_valid === 1'b0, "R1", "rsp_valid", 32'(rsp_valid), 0);
    chk(flash_req === 1'b0, "R1", "flash_req", 32'(flash_req), 0);
    chk(req_ready === 1'b1, "R1", "req_ready", 32'(req_ready), 1);
    reg_check(1'b0, 8'h00, "R1");
    reg_check(1'b1, 8'h07, "R1");

    // R2 / R3: field placement, unused bits, reserved code
    reg_write(1'b0, 8'hFE); reg_check(1'b0, 8'h02, "R2");
    reg_write(1'b0, 8'hFF); reg_check(1'b0, 8'h02, "R3");
    reg_write(1'b1, 8'hFB); reg_check(1'b1, 8'h03, "R2");
    reg_write(1'b0, 8'h00); reg_check(1'b0, 8'h00, "R2");

    // R6: off mode, every read misses (T=3)
    go(16'h0010, 1'b0, 1'b0, 3, 8'h00, "R6");
    go(16'h0010, 1'b0, 1'b0, 3, 8'h00, "R6");
    go(16'h0010, 1'b1, 1'b0, 3, 8'h00, "R6");

    // R4: timing value 0 acts as 1
    reg_write(1'b1, 8'h00); reg_check(1'b1, 8'h00, "R2");
    go(16'h0020, 1'b0, 1'b0, 1, 8'h00, "R4");

    // R7: partial mode, T=4
    reg_write(1'b1, 8'h04);
    reg_write(1'b0, 8'h01);
    go(16'h0040, 1'b0, 1'b0, 4, 8'h00, "R4");
    go(16'h0041, 1'b0, 1'b1, 1, 8'h00, "R5");
    epoch = 8'h01;
    go(16'h0042, 1'b0, 1'b1, 1, 8'h00, "R5");
    go(16'h0080, 1'b1, 1'b0, 4, 8'h01, "R7");
    go(16'h0080, 1'b1, 1'b0, 4, 8'h01, "R7");
    go(16'h0043, 1'b0, 1'b1, 1, 8'h00, "R7");

    // R9: same value keeps lines, a change drops them
    reg_write(1'b0, 8'h01);
    go(16'h0040, 1'b0, 1'b1, 1, 8'h00, "R9");
    reg_write(1'b0, 8'h02);
    go(16'h0040, 1'b0, 1'b0, 4, 8'h01, "R9");

    // R8: full mode, separate instruction and data lines
    go(16'h0080, 1'b1, 1'b0, 4, 8'h01, "R8");
    go(16'h0081, 1'b1, 1'b1, 1, 8'h01, "R8");
    go(16'h0043, 1'b0, 1'b1, 1, 8'h01, "R8");

    // R3: reserved code causes no invalidation
    epoch = 8'h02;
    reg_write(1'b0, 8'h03);
    reg_check(1'b0, 8'h02, "R3");
    go(16'h0041, 1'b0, 1'b1, 1, 8'h01, "R3");

    // R10: mode and timing writes during a 5-cycle access
    reg_write(1'b1, 8'h05);
    send(16'h0100, 1'b0, 1'b0, 5, 8'h02, "R10");
    chk(req_ready === 1'b0, "R11", "req_ready while busy", 32'(req_ready), 0);
    reg_write(1'b0, 8'h01);
    reg_write(1'b1, 8'h02);
    drain();
    go(16'h0100, 1'b0, 1'b0, 2, 8'h02, "R10");
    go(16'h0101, 1'b0, 1'b1, 1, 8'h02, "R10");

    repeat (3) @(negedge clk);
    chk(sb.size() == 0, "R11", "outstanding responses", 32'(sb.size()), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule